// File: doc/BRIEF.md
# IRQ/FIQ Interrupt Controller

This block gathers up to 95 level-sensitive interrupt sources into three banks of 32 bits each. It produces two requests for a processor: a normal interrupt and a fast interrupt. When an enabled source is high at a clock edge, the block records a sticky pending bit. A per-source routing bit decides whether that record goes into the normal-interrupt pending bank or the fast-interrupt pending bank. Software clears a pending bit by writing a one to it, and it can hide any source with a mask bit.

The processor reaches the block through a plain 32-bit register port over a 1 KB window. The port has a strobe, a write enable, an address, write data and registered read data. Four control words (vector, base address, protection and NMI control) are storage only and have no effect on the outputs. Priority arbitration and vector generation sit outside this block.

Top module: `irqfiq_top`

## Requirements
- R1: After reset, every register reads zero, and irq_o, fiq_o and rd_data_o are 0.
- R2: At a clock edge where source n is high and its enable bit is 1, the block sets its pending bit. The bit goes into fast-interrupt pending if select bit n is 1, and into normal-interrupt pending otherwise. A source whose enable bit is 0 sets nothing. A pending bit stays set after the source falls.
- R3: A write to a pending register clears each bit written as 1 and leaves each bit written as 0 unchanged. If a source sets a bit in the same cycle that software clears it, the bit stays set.
- R4: irq_o is registered. It is 1 in the cycle after some source has its normal pending bit set and its mask bit 0.
- R5: fiq_o is registered. It is 1 in the cycle after some source has its fast pending bit, its select bit set and its mask bit 0. A source with mask bit 1 reaches neither output.
- R6: Writes to vector (0x00) and base address (0x04) store bits [1:0] as zero. Protection (0x08) and NMI control (0x0C) store all 32 bits.
- R7: Each per-source register group has three words: normal pending at 0x10, fast pending at 0x20, select at 0x30, enable at 0x40 and mask at 0x50. Address bits [3:2] pick the bank, and bank b holds sources 32b to 32b+31.
- R8: Some addresses are unmapped: any address with bits [1:0] not zero, bank index 3 of any group, and any offset at 0x60 or above. A read from one of these returns zero, and a write to one changes nothing.
- R9: Bits for source numbers 95 and above always read zero in every per-source register.
- R10: Read data is valid in the cycle after the read strobe. It holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | 95 | Interrupt source levels |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 10 | Byte address within the window |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Read data, one cycle after the strobe |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
A source that is high at edge k sets its pending bit at edge k, and the output follows at edge k+1. The bench drives inputs on falling edges. It checks that the output is still low one falling edge after a pulse and high one falling edge later. A pending, mask or select write moves an output one edge after the write edge, so the bench checks outputs one full cycle after each write task returns. Read results are queued as expected values when the strobe is driven, and a monitor compares them at the falling edge right after the strobe's capture edge.

// File: rtl/irqfiq_pkg.sv
package irqfiq_pkg;
  localparam int WORD_W = 32;
  localparam int ADDR_W = 10;

  typedef enum logic [2:0] {
    RG_NONE, RG_CTRL, RG_IPEND, RG_FPEND, RG_SEL, RG_EN, RG_MASK
  } region_e;

  typedef struct packed {
    region_e    region;
    logic [1:0] idx;
  } dec_t;

  // Address decode; idx is the word within a 16-byte group.
  function automatic dec_t decode_addr(input logic [ADDR_W-1:0] a, input int nbank);
    dec_t d;
    d.idx    = a[3:2];
    d.region = RG_NONE;
    if (a[1:0] == 2'b00) begin
      case (a[ADDR_W-1:4])
        6'd0:    d.region = RG_CTRL;
        6'd1:    d.region = RG_IPEND;
        6'd2:    d.region = RG_FPEND;
        6'd3:    d.region = RG_SEL;
        6'd4:    d.region = RG_EN;
        6'd5:    d.region = RG_MASK;
        default: d.region = RG_NONE;
      endcase
    end
    if (d.region != RG_CTRL && d.region != RG_NONE && int'(d.idx) >= nbank)
      d.region = RG_NONE;
    return d;
  endfunction

  // Bits of a bank that map to real sources.
  function automatic logic [WORD_W-1:0] live_bits(input int bank, input int nsrc);
    logic [WORD_W-1:0] m;
    m = '0;
    for (int i = 0; i < WORD_W; i++)
      if (bank * WORD_W + i < nsrc) m[i] = 1'b1;
    return m;
  endfunction

  function automatic logic [WORD_W-1:0] ctrl_store(input logic [1:0] idx,
                                                   input logic [WORD_W-1:0] wd);
    return (idx < 2'd2) ? {wd[WORD_W-1:2], 2'b00} : wd;
  endfunction

  function automatic logic [WORD_W-1:0] next_pending(input logic [WORD_W-1:0] cur,
                                                     input logic clr,
                                                     input logic [WORD_W-1:0] wd,
                                                     input logic [WORD_W-1:0] set);
    return (clr ? (cur & ~wd) : cur) | set;
  endfunction
endpackage

// File: rtl/irqfiq_bank.sv
module irqfiq_bank
  import irqfiq_pkg::*;
#(
  parameter int BANK    = 0,
  parameter int NUM_SRC = 95
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] src,
  input  logic              wr,
  input  region_e           region,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] ipend,
  output logic [WORD_W-1:0] fpend,
  output logic [WORD_W-1:0] sel,
  output logic [WORD_W-1:0] en,
  output logic [WORD_W-1:0] mask,
  output logic [WORD_W-1:0] set_irq,
  output logic [WORD_W-1:0] set_fiq
);
  localparam logic [WORD_W-1:0] LIVE = live_bits(BANK, NUM_SRC);

  logic [WORD_W-1:0] arm;
  assign arm     = src & en & LIVE;
  assign set_irq = arm & ~sel;
  assign set_fiq = arm & sel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ipend <= '0;
      fpend <= '0;
      sel   <= '0;
      en    <= '0;
      mask  <= '0;
    end else begin
      ipend <= next_pending(ipend, wr && region == RG_IPEND, wdata, set_irq);
      fpend <= next_pending(fpend, wr && region == RG_FPEND, wdata, set_fiq);
      if (wr && region == RG_SEL)  sel  <= wdata & LIVE;
      if (wr && region == RG_EN)   en   <= wdata & LIVE;
      if (wr && region == RG_MASK) mask <= wdata & LIVE;
    end
  end
endmodule

// File: rtl/irqfiq_ctrl_regs.sv
module irqfiq_ctrl_regs
  import irqfiq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [1:0]        idx,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] regs [4]
);
  for (genvar g = 0; g < 4; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n)                         regs[g] <= '0;
      else if (wr && idx == 2'(g))        regs[g] <= ctrl_store(2'(g), wdata);
    end
  end
endmodule

// File: rtl/irqfiq_outgen.sv
module irqfiq_outgen #(
  parameter int W = 96
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] ipend,
  input  logic [W-1:0] fpend,
  input  logic [W-1:0] sel,
  input  logic [W-1:0] mask,
  output logic         irq_req,
  output logic         fiq_req,
  output logic         irq_o,
  output logic         fiq_o
);
  assign irq_req = |(ipend & ~mask);
  assign fiq_req = |(fpend & sel & ~mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_o <= 1'b0;
      fiq_o <= 1'b0;
    end else begin
      irq_o <= irq_req;
      fiq_o <= fiq_req;
    end
  end
endmodule

// File: rtl/irqfiq_top.sv
module irqfiq_top
  import irqfiq_pkg::*;
#(
  parameter int NUM_SRC = 95
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [WORD_W-1:0]  wr_data_i,
  output logic [WORD_W-1:0]  rd_data_o,
  output logic               irq_o,
  output logic               fiq_o
);
  localparam int NBANK = (NUM_SRC + WORD_W - 1) / WORD_W;
  localparam int SPAD  = NBANK * WORD_W;

  dec_t dec;
  logic wr_go, rd_go;
  assign dec   = decode_addr(addr_i, NBANK);
  assign wr_go = req_i && we_i;
  assign rd_go = req_i && !we_i;

  logic [SPAD-1:0] src_pad;
  always_comb begin
    src_pad = '0;
    src_pad[NUM_SRC-1:0] = src_i;
  end

  // Flattened per-source state, visible to the checker.
  logic [SPAD-1:0] irq_pend_all, fiq_pend_all, sel_all, en_all, mask_all;
  logic [SPAD-1:0] set_irq_all, set_fiq_all;
  logic            irq_req, fiq_req;
  logic [WORD_W-1:0] ctrl_q [4];

  irqfiq_ctrl_regs u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (wr_go && dec.region == RG_CTRL),
    .idx   (dec.idx),
    .wdata (wr_data_i),
    .regs  (ctrl_q)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    irqfiq_bank #(.BANK(b), .NUM_SRC(NUM_SRC)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .src     (src_pad[b*WORD_W +: WORD_W]),
      .wr      (wr_go && int'(dec.idx) == b),
      .region  (dec.region),
      .wdata   (wr_data_i),
      .ipend   (irq_pend_all[b*WORD_W +: WORD_W]),
      .fpend   (fiq_pend_all[b*WORD_W +: WORD_W]),
      .sel     (sel_all[b*WORD_W +: WORD_W]),
      .en      (en_all[b*WORD_W +: WORD_W]),
      .mask    (mask_all[b*WORD_W +: WORD_W]),
      .set_irq (set_irq_all[b*WORD_W +: WORD_W]),
      .set_fiq (set_fiq_all[b*WORD_W +: WORD_W])
    );
  end

  irqfiq_outgen #(.W(SPAD)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .ipend   (irq_pend_all),
    .fpend   (fiq_pend_all),
    .sel     (sel_all),
    .mask    (mask_all),
    .irq_req (irq_req),
    .fiq_req (fiq_req),
    .irq_o   (irq_o),
    .fiq_o   (fiq_o)
  );

  logic [WORD_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (dec.region == RG_CTRL) rd_mux = ctrl_q[dec.idx];
    for (int b = 0; b < NBANK; b++) begin
      if (int'(dec.idx) == b) begin
        case (dec.region)
          RG_IPEND: rd_mux = irq_pend_all[b*WORD_W +: WORD_W];
          RG_FPEND: rd_mux = fiq_pend_all[b*WORD_W +: WORD_W];
          RG_SEL:   rd_mux = sel_all[b*WORD_W +: WORD_W];
          RG_EN:    rd_mux = en_all[b*WORD_W +: WORD_W];
          RG_MASK:  rd_mux = mask_all[b*WORD_W +: WORD_W];
          default:  ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rd_data_o <= '0;
    else if (rd_go) rd_data_o <= rd_mux;
  end
endmodule

// File: rtl/irqfiq_chk.sv
module irqfiq_chk #(
  parameter int NUM_SRC = 95,
  parameter int SPAD    = 96
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_i,
  input logic               we_i,
  input logic [NUM_SRC-1:0] src_i,
  input logic               irq_o,
  input logic               fiq_o,
  input logic [SPAD-1:0]    irq_pend_all,
  input logic [SPAD-1:0]    fiq_pend_all,
  input logic [SPAD-1:0]    sel_all,
  input logic [SPAD-1:0]    en_all,
  input logic [SPAD-1:0]    mask_all,
  input logic [31:0]        vec_q,
  input logic [31:0]        base_q
);
  logic [SPAD-1:0] src_w, arm_irq, arm_fiq, dead;
  always_comb begin
    src_w = '0;
    src_w[NUM_SRC-1:0] = src_i;
    dead = '1;
    dead[NUM_SRC-1:0] = '0;
  end
  assign arm_irq = src_w & en_all & ~sel_all;
  assign arm_fiq = src_w & en_all & sel_all;

  // R4: normal request follows unmasked normal pending one cycle later
  p_irq_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == $past(|(irq_pend_all & ~mask_all)));

  // R5: fast request follows selected, unmasked fast pending one cycle later
  p_fiq_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_o == $past(|(fiq_pend_all & sel_all & ~mask_all)));

  // R2 and R3: an armed source is pending next cycle even under a clear
  p_irq_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|arm_irq) |=> ((irq_pend_all & $past(arm_irq)) == $past(arm_irq)));
  p_fiq_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|arm_fiq) |=> ((fiq_pend_all & $past(arm_fiq)) == $past(arm_fiq)));

  // R2: a pending bit only rises where its source was armed
  p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pend_all & ~$past(irq_pend_all) & ~$past(arm_irq)) == '0);

  // R3: pending bits fall only after a register write
  p_fall_needs_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(irq_pend_all) & ~irq_pend_all) || |($past(fiq_pend_all) & ~fiq_pend_all))
      |-> $past(req_i && we_i));

  // R9: bits for absent sources stay zero
  p_dead_bits_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_pend_all | fiq_pend_all | sel_all | en_all | mask_all) & dead) == '0);

  // R6: vector and base address keep their low bits clear
  p_align_r6: assert property (@(posedge clk) disable iff (!rst_n)
    vec_q[1:0] == 2'b00 && base_q[1:0] == 2'b00);
endmodule

bind irqfiq_top irqfiq_chk #(.NUM_SRC(NUM_SRC), .SPAD(SPAD)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_i        (req_i),
  .we_i         (we_i),
  .src_i        (src_i),
  .irq_o        (irq_o),
  .fiq_o        (fiq_o),
  .irq_pend_all (irq_pend_all),
  .fiq_pend_all (fiq_pend_all),
  .sel_all      (sel_all),
  .en_all       (en_all),
  .mask_all     (mask_all),
  .vec_q        (ctrl_q[0]),
  .base_q       (ctrl_q[1])
);

// File: tb/tb_irqfiq_top.sv
module tb_irqfiq_top;
  localparam int NS = 95;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] src = '0;
  logic          req = 1'b0, we = 1'b0;
  logic [9:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          irq, fiq;

  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  irqfiq_top dut (
    .clk(clk), .rst_n(rst_n), .src_i(src), .req_i(req), .we_i(we),
    .addr_i(addr), .wr_data_i(wdata), .rd_data_o(rdata),
    .irq_o(irq), .fiq_o(fiq)
  );

  // Scoreboard of expected read results
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_fire = 1'b0;

  always @(posedge clk) rd_fire <= req && !we && rst_n;

  always @(negedge clk) begin
    if (rd_fire && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (rdata !== e) begin
        fails++;
        $display("FAIL %s (R10 timing) read: got %h expected %h", t, rdata, e);
      end
    end
  end

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic rd(input logic [9:0] a, input logic [31:0] e, input string t);
    @(negedge clk); req = 1; we = 0; addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk); req = 0;
  endtask

  task automatic pulse(input int n);
    @(negedge clk); src[n] = 1'b1;
    @(negedge clk); src[n] = 1'b0;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk_out(input logic ei, input logic ef, input string t);
    checks++;
    if (irq !== ei || fiq !== ef) begin
      fails++;
      $display("FAIL %s outputs: irq=%b fiq=%b expected irq=%b fiq=%b", t, irq, fiq, ei, ef);
    end
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    // R1: reset state
    chk_out(0, 0, "R1");
    checks++;
    if (rdata !== 32'h0) begin
      fails++;
      $display("FAIL R1 rd_data: got %h expected 0", rdata);
    end
    for (int r = 0; r < 4; r++) rd(10'(r * 4), 32'h0, "R1 ctrl");
    for (int g = 1; g <= 5; g++)
      for (int b = 0; b < 3; b++) rd(10'(g * 16 + b * 4), 32'h0, "R1 bank");

    // R6: control word storage
    wr(10'h000, 32'hFFFF_FFFF); rd(10'h000, 32'hFFFF_FFFC, "R6 vector");
    wr(10'h004, 32'h1234_5677); rd(10'h004, 32'h1234_5674, "R6 base");
    wr(10'h008, 32'hDEAD_BEEF); rd(10'h008, 32'hDEAD_BEEF, "R10 R6 protection");
    wr(10'h00C, 32'h0000_0003); rd(10'h00C, 32'h0000_0003, "R6 nmi");

    // R2/R4: enabled source latches into normal pending
    wr(10'h040, 32'hFFFF_FFFF);
    pulse(5);
    chk_out(0, 0, "R4 latency");
    step();
    chk_out(1, 0, "R4");
    rd(10'h010, 32'h0000_0020, "R2 latched");
    rd(10'h020, 32'h0, "R2 not fast");

    // R2: disabled source sets nothing
    pulse(40);
    rd(10'h014, 32'h0, "R2 disabled");

    // R3: write-one-to-clear
    wr(10'h010, 32'h0000_0001); rd(10'h010, 32'h0000_0020, "R3 zero bits kept");
    wr(10'h010, 32'h0000_0020); step();
    chk_out(0, 0, "R3 cleared");
    rd(10'h010, 32'h0, "R3 cleared");

    // R5/R9: routing to fast pending, bank 2 source 67
    wr(10'h048, 32'hFFFF_FFFF); rd(10'h048, 32'h7FFF_FFFF, "R9 enable");
    wr(10'h038, 32'h0000_0008);
    pulse(67); step();
    chk_out(0, 1, "R5");
    rd(10'h028, 32'h0000_0008, "R2 fast pending");
    rd(10'h018, 32'h0, "R2 normal untouched");

    // R5: mask and select gating
    wr(10'h058, 32'h0000_0008); step(); chk_out(0, 0, "R5 masked");
    wr(10'h058, 32'h0);         step(); chk_out(0, 1, "R5 unmasked");
    wr(10'h038, 32'h0);         step(); chk_out(0, 0, "R5 select off");
    rd(10'h028, 32'h0000_0008, "R5 pending kept");
    wr(10'h028, 32'h0000_0008); rd(10'h028, 32'h0, "R3 fast clear");

    // R4: mask on normal path
    pulse(5); step(); chk_out(1, 0, "R4 set");
    wr(10'h050, 32'h0000_0020); step(); chk_out(0, 0, "R4 masked");
    wr(10'h050, 32'h0);         step(); chk_out(1, 0, "R4 unmasked");

    // R3: set wins over clear in the same cycle
    @(negedge clk); src[5] = 1'b1; req = 1; we = 1; addr = 10'h010; wdata = 32'h20;
    @(negedge clk); src[5] = 1'b0; req = 0; we = 0;
    rd(10'h010, 32'h0000_0020, "R3 set wins");
    wr(10'h010, 32'h0000_0020); step(); chk_out(0, 0, "R3 final clear");

    // R7: bank addressing
    wr(10'h054, 32'h00AA_0055);
    rd(10'h054, 32'h00AA_0055, "R7 bank1");
    rd(10'h050, 32'h0, "R7 bank0");
    rd(10'h058, 32'h0, "R7 bank2");

    // R8: unmapped accesses
    wr(10'h01C, 32'hFFFF_FFFF); rd(10'h01C, 32'h0, "R8 bank3");
    rd(10'h060, 32'h0, "R8 above map");
    rd(10'h3FC, 32'h0, "R8 top of window");
    wr(10'h04C, 32'hFFFF_FFFF);
    wr(10'h041, 32'h0);
    rd(10'h040, 32'hFFFF_FFFF, "R8 enable0 kept");
    rd(10'h044, 32'h0, "R8 enable1 kept");
    rd(10'h048, 32'h7FFF_FFFF, "R8 enable2 kept");
    wr(10'h00E, 32'h0000_0055); rd(10'h00C, 32'h0000_0003, "R8 unaligned");

    // R9: absent source bits stay zero
    wr(10'h038, 32'hFFFF_FFFF); rd(10'h038, 32'h7FFF_FFFF, "R9 select");
    wr(10'h058, 32'hFFFF_FFFF); rd(10'h058, 32'h7FFF_FFFF, "R9 mask");
    pulse(94); step();
    chk_out(0, 0, "R5 top source masked");
    rd(10'h028, 32'h4000_0000, "R9 source 94");

    step(); step();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule